// File: doc/BRIEF.md
# Descriptor Burst Planner

This block sits inside a network controller's DMA engine and decides how descriptor traffic is cut into bus bursts. It uses the cache line size programmed by system software, the bus mode, the fetch side of the descriptor ring, and the set of completed descriptors that still have to be written back to memory. From these it plans one request at a time. A read burst fetches new descriptors. A write burst returns completed descriptors to host memory. Every burst is cut so that it never crosses a cache line boundary, the end of the ring or the producer pointer.

A write-back goes out as soon as the completed descriptors reach the next line boundary. A flush input pushes out a shorter run. On a conventional bus, a write-back that covers exactly one aligned, supported cache line uses the invalidating write command. Every other write uses the plain write command. On a PCI-X bus the line size still sets the burst sizing, but it has no effect on the command. The planned request is held in a single output register with a valid/ready handshake. The DMA engine advances its pointers after each accepted request.

Top module: `desc_burst_planner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_valid` is 0. With no fetchable or pending descriptors it stays 0.
- R2: `cls_words` counts 32-bit words. The line size in bytes is 4×`cls_words`, clamped to 128. A line of 16, 32, 64 or 128 bytes holds 1, 2, 4 or 8 descriptors (16 bytes each). A value of 32 or more words therefore gives 8 descriptors per line.
- R3: Any other line size, including 0 or a non-power-of-two, gives single-descriptor requests, and a write-back then always uses command 0x7.
- R4: A fetch starts at descriptor `fetch_head` when `fetch_tail` ≠ `fetch_head`. `req_addr` = `ring_base` + 16×index, where `ring_base` is 128-byte aligned. `req_wb`=0 and `req_cmd` = 0x6 (memory read). The count runs up to the next line boundary in descriptor index.
- R5: A fetch count is the minimum of the descriptors left to the line boundary, the descriptors before `fetch_tail` (modulo `ring_len`) and the descriptors left before the ring end.
- R6: A write-back (`req_wb`=1) starting at `wb_head` is issued when `wb_pending` is at least the distance to the next line boundary or ring end. Its count is that distance. Fewer pending descriptors produce no request.
- R7: With `wb_flush` high and `wb_pending` > 0 but short of that distance, one write-back of all pending descriptors is issued with command 0x7 (memory write).
- R8: On a conventional bus (`pcix_mode`=0), a write-back uses command 0xF (write and invalidate) exactly when it starts on a line boundary, its count equals a full supported line, and R3 does not apply.
- R9: With `pcix_mode`=1 every write-back uses command 0x7, while burst counts stay as in R5 and R6.
- R10: When a write-back and a fetch are both possible in the same cycle, the write-back is planned first.
- R11: While `req_valid`=1 and `req_ready`=0 the request fields are held unchanged. After an accepted request, `req_valid` is 0 for at least one cycle before the next plan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_words | input | 8 | Programmed cache line size in 32-bit words |
| pcix_mode | input | 1 | 1 = PCI-X bus, 0 = conventional bus |
| ring_base | input | 32 | Byte address of ring entry 0, 128-byte aligned |
| ring_len | input | 9 | Number of descriptors in the ring |
| fetch_head | input | 8 | Next descriptor index to fetch |
| fetch_tail | input | 8 | Producer index; descriptors before it are fetchable |
| wb_head | input | 8 | Index of the first completed descriptor not yet written back |
| wb_pending | input | 9 | Number of completed descriptors starting at `wb_head` |
| wb_flush | input | 1 | Force write-back of a partial line |
| req_ready | input | 1 | Consumer accepts the request this cycle |
| req_valid | output | 1 | A planned request is present |
| req_wb | output | 1 | 1 = write-back, 0 = fetch |
| req_addr | output | 32 | Start byte address |
| req_count | output | 4 | Descriptors in the burst (1..8) |
| req_cmd | output | 4 | Bus command: 0x6 read, 0x7 write, 0xF write and invalidate |

## Verification
The bench probes a fetch that starts partway into a line. A planner that ignores line alignment would fetch across the boundary and return a count too large. A fetch that wraps at a ring whose length is not a multiple of the line catches a design that overruns the ring end. A line size above the clamp catches a design that would return zero or oversized counts. The unsupported sizes 12 and 0 words catch a design that would issue multi-descriptor bursts or invalidating writes. On the write side, three descriptors pending against a four-descriptor line must give silence until the flush, and then a plain write. An unaligned run must be split so that only the aligned full line uses 0xF. PCI-X mode must never produce 0xF. Stalled ready cycles expose any request that changes before acceptance.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  typedef enum logic [3:0] {
    CMD_MEM_READ      = 4'h6,
    CMD_MEM_WRITE     = 4'h7,
    CMD_MEM_WRITE_INV = 4'hF
  } bus_cmd_e;

  typedef struct packed {
    logic [15:0] per_line;
    logic        whole_ok;
  } line_cfg_t;

  // words -> bytes, clamp, then accept only power-of-two lines >= one descriptor
  function automatic line_cfg_t decode_line(input int words, input int max_bytes,
                                            input int desc_bytes);
    line_cfg_t r;
    int bytes;
    bytes = words * 4;
    if (bytes > max_bytes) bytes = max_bytes;
    r.per_line = 16'd1;
    r.whole_ok = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if ((desc_bytes << k) <= max_bytes && bytes == (desc_bytes << k)) begin
        r.per_line = 16'(1 << k);
        r.whole_ok = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] min2(input logic [15:0] a, input logic [15:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/dbp_line_cfg.sv
module dbp_line_cfg #(
  parameter int CLS_W          = 8,
  parameter int CW             = 4,
  parameter int DESC_BYTES     = 16,
  parameter int MAX_LINE_BYTES = 128
) (
  input  logic [CLS_W-1:0] cls_words,
  output logic [CW-1:0]    per_line,
  output logic             whole_ok
);
  import dbp_pkg::*;

  line_cfg_t cfg;

  always_comb begin
    cfg      = decode_line(int'(cls_words), MAX_LINE_BYTES, DESC_BYTES);
    per_line = CW'(cfg.per_line);
    whole_ok = cfg.whole_ok;
  end
endmodule

// File: rtl/dbp_fetch_plan.sv
module dbp_fetch_plan #(
  parameter int IW = 8,
  parameter int CW = 4
) (
  input  logic [IW:0]   ring_len,
  input  logic [IW-1:0] head,
  input  logic [IW-1:0] tail,
  input  logic [CW-1:0] per_line,
  output logic          go,
  output logic [CW-1:0] count
);
  import dbp_pkg::*;
  localparam int LW = IW + 1;

  logic [LW-1:0] head_x, tail_x, avail, to_end, to_line, mask;
  logic [15:0]   best;

  always_comb begin
    head_x  = {1'b0, head};
    tail_x  = {1'b0, tail};
    avail   = (tail_x >= head_x) ? (tail_x - head_x) : (ring_len - head_x + tail_x);
    to_end  = ring_len - head_x;
    mask    = LW'(per_line) - LW'(1);
    to_line = LW'(per_line) - (head_x & mask);
    best    = min2(min2(16'(to_line), 16'(avail)), 16'(to_end));
    go      = (avail != '0);
    count   = CW'(best);
  end
endmodule

// File: rtl/dbp_wb_plan.sv
module dbp_wb_plan #(
  parameter int IW = 8,
  parameter int CW = 4
) (
  input  logic [IW:0]   ring_len,
  input  logic [IW-1:0] wb_head,
  input  logic [IW:0]   wb_pending,
  input  logic [CW-1:0] per_line,
  input  logic          whole_ok,
  input  logic          pcix_mode,
  input  logic          flush,
  output logic          go,
  output logic [CW-1:0] count,
  output logic          use_inv
);
  import dbp_pkg::*;
  localparam int LW = IW + 1;

  logic [LW-1:0] head_x, to_end, to_line, mask;
  logic [15:0]   room, take;
  logic          filled, on_line;

  always_comb begin
    head_x  = {1'b0, wb_head};
    to_end  = ring_len - head_x;
    mask    = LW'(per_line) - LW'(1);
    to_line = LW'(per_line) - (head_x & mask);
    room    = min2(16'(to_line), 16'(to_end));
    filled  = 16'(wb_pending) >= room;
    go      = (wb_pending != '0) && (filled || flush);
    take    = filled ? room : 16'(wb_pending);
    count   = CW'(take);
    on_line = (head_x & mask) == '0;
    use_inv = !pcix_mode && whole_ok && on_line && (take == 16'(per_line));
  end
endmodule

// File: rtl/desc_burst_planner.sv
module desc_burst_planner #(
  parameter int AW             = 32,
  parameter int IW             = 8,
  parameter int CLS_W          = 8,
  parameter int DESC_BYTES     = 16,
  parameter int MAX_LINE_BYTES = 128,
  localparam int MAXD          = MAX_LINE_BYTES / DESC_BYTES,
  localparam int CW            = $clog2(MAXD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_W-1:0] cls_words,
  input  logic             pcix_mode,
  input  logic [AW-1:0]    ring_base,
  input  logic [IW:0]      ring_len,
  input  logic [IW-1:0]    fetch_head,
  input  logic [IW-1:0]    fetch_tail,
  input  logic [IW-1:0]    wb_head,
  input  logic [IW:0]      wb_pending,
  input  logic             wb_flush,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_wb,
  output logic [AW-1:0]    req_addr,
  output logic [CW-1:0]    req_count,
  output logic [3:0]       req_cmd
);
  import dbp_pkg::*;

  logic [CW-1:0] per_line;
  logic          whole_ok;
  logic          fetch_go, wb_go, wb_inv, load, accept;
  logic [CW-1:0] fetch_cnt, wb_cnt;
  logic [IW-1:0] start_idx;

  dbp_line_cfg #(.CLS_W(CLS_W), .CW(CW), .DESC_BYTES(DESC_BYTES),
                 .MAX_LINE_BYTES(MAX_LINE_BYTES)) u_cfg (
    .cls_words(cls_words), .per_line(per_line), .whole_ok(whole_ok));

  dbp_fetch_plan #(.IW(IW), .CW(CW)) u_fetch (
    .ring_len(ring_len), .head(fetch_head), .tail(fetch_tail),
    .per_line(per_line), .go(fetch_go), .count(fetch_cnt));

  dbp_wb_plan #(.IW(IW), .CW(CW)) u_wb (
    .ring_len(ring_len), .wb_head(wb_head), .wb_pending(wb_pending),
    .per_line(per_line), .whole_ok(whole_ok), .pcix_mode(pcix_mode),
    .flush(wb_flush), .go(wb_go), .count(wb_cnt), .use_inv(wb_inv));

  assign accept    = req_valid && req_ready;
  assign load      = !req_valid && (wb_go || fetch_go);
  assign start_idx = wb_go ? wb_head : fetch_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_wb    <= 1'b0;
      req_addr  <= '0;
      req_count <= '0;
      req_cmd   <= CMD_MEM_READ;
    end else if (accept) begin
      req_valid <= 1'b0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_wb    <= wb_go;
      req_addr  <= ring_base + (AW'(start_idx) * AW'(DESC_BYTES));
      req_count <= wb_go ? wb_cnt : fetch_cnt;
      if (!wb_go)      req_cmd <= CMD_MEM_READ;
      else if (wb_inv) req_cmd <= CMD_MEM_WRITE_INV;
      else             req_cmd <= CMD_MEM_WRITE;
    end
  end
endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
  parameter int AW         = 32,
  parameter int CW         = 4,
  parameter int DESC_SHIFT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pcix_mode,
  input logic [AW-1:0] ring_base,
  input logic          req_ready,
  input logic          req_valid,
  input logic          req_wb,
  input logic [AW-1:0] req_addr,
  input logic [CW-1:0] req_count,
  input logic [3:0]    req_cmd,
  input logic [CW-1:0] per_line,
  input logic          load,
  input logic          wb_go
);
  logic [AW-1:0] idx_of_req;
  logic [CW-1:0] line_off;

  assign idx_of_req = (req_addr - ring_base) >> DESC_SHIFT;
  assign line_off   = CW'(idx_of_req) & (per_line - CW'(1));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_count)
      && $stable(req_cmd) && $stable(req_wb));

  a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  a_r10_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load && wb_go |=> req_valid && req_wb);

  a_r4_fetch_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_wb |-> req_cmd == 4'h6);

  a_r5_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> req_count != '0 && ({1'b0, line_off} + {1'b0, req_count}) <= {1'b0, per_line});

  a_r8_inv_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_cmd == 4'hF |-> req_wb && !pcix_mode && req_count == per_line
      && line_off == '0);

  a_r9_pcix_plain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && pcix_mode |-> req_cmd != 4'hF);

  a_r7_partial_plain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_wb && req_count < per_line |-> req_cmd == 4'h7);
endmodule

bind desc_burst_planner dbp_checker #(.AW(AW), .CW(CW), .DESC_SHIFT($clog2(DESC_BYTES))) u_chk (
  .clk(clk), .rst_n(rst_n), .pcix_mode(pcix_mode), .ring_base(ring_base),
  .req_ready(req_ready), .req_valid(req_valid), .req_wb(req_wb), .req_addr(req_addr),
  .req_count(req_count), .req_cmd(req_cmd), .per_line(per_line), .load(load), .wb_go(wb_go));

// File: tb/desc_burst_planner_test.sv
module desc_burst_planner_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  cls_words = 8'd16;
  logic        pcix_mode = 0;
  logic [31:0] ring_base = 32'h1000;
  logic [8:0]  ring_len = 9'd32;
  logic [7:0]  fetch_head = 0, fetch_tail = 0, wb_head = 0;
  logic [8:0]  wb_pending = 0;
  logic        wb_flush = 0, req_ready = 0;
  logic        req_valid, req_wb;
  logic [31:0] req_addr;
  logic [3:0]  req_count, req_cmd;

  desc_burst_planner uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit stall_mode = 0, done = 0, acc_flag = 0;
  string tag = "R1";

  typedef struct { bit wb; logic [31:0] addr; int cnt; logic [3:0] cmd; } rq_t;
  rq_t seen[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference
  bit ev = 0, ew = 0; int ec = 0; logic [31:0] ea = 0; logic [3:0] ecmd = 0;

  function automatic void line_info(input int w, output int dpl, output bit full);
    int b;
    b = w * 4;
    if (b > 128) b = 128;
    dpl = 1; full = 0;
    if (b == 16 || b == 32 || b == 64 || b == 128) begin dpl = b / 16; full = 1; end
  endfunction

  always @(posedge clk) begin
    int dpl, room, idx, n, av, len, h, t, wh, pd;
    bit full;
    cyc++;
    if (!rst_n) ev = 0;
    else if (ev) begin
      if (req_ready) ev = 0;
    end else begin
      line_info(int'(cls_words), dpl, full);
      len = int'(ring_len); h = int'(fetch_head); t = int'(fetch_tail);
      wh = int'(wb_head); pd = int'(wb_pending);
      room = 0; idx = wh;
      do begin room++; idx++; end while (idx < len && idx % dpl != 0);
      if (pd > 0 && (pd >= room || wb_flush)) begin
        ev = 1; ew = 1; ec = (pd >= room) ? room : pd; ea = ring_base + 32'(wh * 16);
        ecmd = (!pcix_mode && full && wh % dpl == 0 && ec == dpl) ? 4'hF : 4'h7;
      end else begin
        av = (t >= h) ? t - h : len - h + t;
        if (av > 0) begin
          n = 0; idx = h;
          do begin n++; idx++; end while (n < av && idx < len && idx % dpl != 0);
          ev = 1; ew = 0; ec = n; ea = ring_base + 32'(h * 16); ecmd = 4'h6;
        end
      end
    end
  end

  // per-cycle compare, consumer pointer updates, ready pattern
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_valid == ev, tag, "valid vs model", req_valid, ev);
      if (ev && req_valid)
        chk(req_wb == ew && req_addr == ea && int'(req_count) == ec && req_cmd == ecmd,
            tag, "fields vs model", {req_wb, req_addr, req_count, req_cmd},
            {ew, ea, 4'(ec), ecmd});
    end
    if (acc_flag) begin
      if (seen[$].wb) begin
        wb_head = 8'((int'(wb_head) + seen[$].cnt) % int'(ring_len));
        wb_pending = wb_pending - 9'(seen[$].cnt);
      end else
        fetch_head = 8'((int'(fetch_head) + seen[$].cnt) % int'(ring_len));
    end
    req_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    acc_flag = rst_n && req_valid && req_ready;
    if (acc_flag) seen.push_back('{req_wb, req_addr, int'(req_count), req_cmd});
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input string t);
    @(negedge clk); #1;
    tag = t;
    seen.delete();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid == 0, "R1", "valid in reset", req_valid, 0);
    rst_n = 1;
    settle(1);
    chk(req_valid == 0, "R1", "valid after reset", req_valid, 0);
    settle(5);
    chk(req_valid == 0, "R1", "idle with nothing to do", req_valid, 0);

    // R4: 64-byte line, fetch starts mid-line
    start("R4"); cls_words = 8'd16; fetch_head = 1; fetch_tail = 10;
    settle(40);
    chk(seen.size() == 3, "R4", "fetch request count", seen.size(), 3);
    if (seen.size() == 3) begin
      chk(seen[0].addr == 32'h1010 && seen[0].cnt == 3 && seen[0].cmd == 4'h6 && !seen[0].wb,
          "R4", "first fetch", {seen[0].addr, 4'(seen[0].cnt)}, {32'h1010, 4'd3});
      chk(seen[2].addr == 32'h1080 && seen[2].cnt == 2, "R4", "tail-clipped fetch",
          seen[2].cnt, 2);
    end

    // R5: ring of 30, wrap at ring end
    start("R5"); ring_len = 9'd30; cls_words = 8'd32; fetch_head = 28; fetch_tail = 3;
    settle(40);
    chk(seen.size() == 2, "R5", "wrap request count", seen.size(), 2);
    if (seen.size() == 2) begin
      chk(seen[0].addr == 32'h11C0 && seen[0].cnt == 2, "R5", "ring-end clip",
          seen[0].cnt, 2);
      chk(seen[1].addr == 32'h1000 && seen[1].cnt == 3, "R5", "after wrap", seen[1].cnt, 3);
    end

    // R2: clamp above 128 bytes, with a stalling consumer (R11)
    start("R2"); ring_len = 9'd32; cls_words = 8'd64; fetch_head = 0; fetch_tail = 20;
    stall_mode = 1;
    settle(3);
    while (!(req_valid && !req_ready)) @(negedge clk);
    begin
      logic [31:0] a0; logic [3:0] c0;
      a0 = req_addr; c0 = req_count;
      @(negedge clk);
      chk(req_valid && req_addr == a0 && req_count == c0, "R11", "held while stalled",
          {req_addr, req_count}, {a0, c0});
    end
    settle(60);
    stall_mode = 0;
    chk(seen.size() == 3 && seen[0].cnt == 8 && seen[2].cnt == 4, "R2", "clamped line",
        seen.size() > 0 ? seen[0].cnt : 0, 8);
    start("R2"); cls_words = 8'd8; fetch_head = 20; fetch_tail = 25;
    settle(30);
    chk(seen.size() == 3 && seen[0].cnt == 2 && seen[2].cnt == 1, "R2", "32-byte line",
        seen.size(), 3);

    // R3: unsupported sizes
    start("R3"); cls_words = 8'd12; fetch_head = 0; fetch_tail = 3;
    settle(30);
    chk(seen.size() == 3 && seen[0].cnt == 1, "R3", "48-byte falls back", seen.size(), 3);
    start("R3"); cls_words = 8'd0; fetch_head = 3; fetch_tail = 4;
    settle(20);
    chk(seen.size() == 1 && seen[0].cnt == 1, "R3", "zero size", seen.size(), 1);

    // R8: aligned full line -> invalidating write
    start("R8"); cls_words = 8'd16; fetch_head = 4; fetch_tail = 4; wb_head = 4; wb_pending = 4;
    settle(20);
    chk(seen.size() == 1 && seen[0].wb && seen[0].addr == 32'h1040 && seen[0].cnt == 4
        && seen[0].cmd == 4'hF, "R8", "full line write",
        seen.size() > 0 ? seen[0].cmd : 0, 4'hF);

    // R6: partial line waits
    start("R6"); wb_pending = 3;
    settle(20);
    chk(seen.size() == 0 && !req_valid, "R6", "no write below a line", seen.size(), 0);
    // R7: flush
    start("R7"); wb_flush = 1;
    settle(20);
    chk(seen.size() == 1 && seen[0].cnt == 3 && seen[0].cmd == 4'h7, "R7", "flushed partial",
        seen.size() > 0 ? seen[0].cmd : 0, 4'h7);
    wb_flush = 0;

    // R6: unaligned run split at the boundary
    start("R6"); wb_head = 11; wb_pending = 6;
    settle(30);
    chk(seen.size() == 2, "R6", "split write count", seen.size(), 2);
    if (seen.size() == 2) begin
      chk(seen[0].cnt == 1 && seen[0].cmd == 4'h7, "R6", "lead-in plain write",
          seen[0].cmd, 4'h7);
      chk(seen[1].addr == 32'h10C0 && seen[1].cnt == 4 && seen[1].cmd == 4'hF, "R8",
          "aligned line after split", seen[1].cmd, 4'hF);
    end

    // R9: PCI-X never invalidates
    start("R9"); pcix_mode = 1; wb_head = 16; wb_pending = 4;
    settle(20);
    chk(seen.size() == 1 && seen[0].cnt == 4 && seen[0].cmd == 4'h7, "R9", "pcix write",
        seen.size() > 0 ? seen[0].cmd : 0, 4'h7);
    pcix_mode = 0;

    // R10: write-back before fetch
    start("R10"); fetch_head = 20; fetch_tail = 24; wb_head = 20; wb_pending = 4;
    settle(30);
    chk(seen.size() == 2 && seen[0].wb && !seen[1].wb, "R10", "write-back first",
        seen.size() > 0 ? seen[0].wb : 0, 1);

    // R3: unsupported size on the write side
    start("R3"); cls_words = 8'd0; wb_head = 24; wb_pending = 2;
    settle(20);
    chk(seen.size() == 2 && seen[0].cnt == 1 && seen[0].cmd == 4'h7 && seen[1].cmd == 4'h7,
        "R3", "single plain writes", seen.size(), 2);

    finish_run();
  end
endmodule